// File: doc/BRIEF.md
# Processor Reset Exception Sequencer

This block runs the processor's reset processing. While the active-low reset is held, it forces the supervisor state to its power-on values. The status register comes up in supervisor mode with tracing off, the master-state bit clear and the interrupt mask at level 7. The vector base is zero and every local-memory enable is cleared. Reset is asynchronous and has the highest priority: it abandons whatever the sequencer was doing, and that work cannot be resumed.

After reset is released, the sequencer counts a fixed sampling window of `DLY` cycles (16 by default). During that window it watches the debug halt request. If a halt was seen, it parks in a debug-halt state until the request drops. Otherwise it issues two longword reads on a simple request/response port. The word at address 0 becomes the stack pointer and the word at address 4 becomes the program counter. It then raises `run_o` and presents the loaded PC as the first fetch address.

An error response on either read, or a core-reported access/address fault before the first instruction retires, moves the block to a fault-on-fault halt. Only a new reset leaves that halt. Once the first instruction has retired, the core may write the supervisor registers through a small write port.

Top module: `boot_seq`

## Requirements
- R1: Driving `rst_ni` low takes effect immediately, in any state: `rd_req_o`, `run_o`, `dbg_halt_o` and `fault_o` drop to 0 without waiting for a clock edge.
- R2: `sr_o` equals 16'h2700 during reset and until the first instruction retires. In that value, bit 13 (supervisor) is 1, bit 15 (trace) is 0, bit 12 (master) is 0 and bits 10:8 (interrupt mask) are 3'b111.
- R3: `vbr_o` is zero during reset and until the first instruction retires.
- R4: every bit of `mem_en_o` is 0 during reset and until the first instruction retires.
- R5: no read is requested during the first `DLY` clock edges after reset release. The first request appears at the `DLY`-th edge.
- R6: if `halt_req_i` is high on any edge of the sampling window, `dbg_halt_o` is asserted with no read and no run until `halt_req_i` is low. Boot then continues. A halt request raised after the window is ignored.
- R7: the first read targets address 0 and its data loads `sp_o`. The second read targets address 4 and its data loads `pc_o`. A request holds its address until `rd_ack_i` or `rd_err_i`.
- R8: `run_o` rises on the edge after the PC read is acknowledged, and `fetch_addr_o` then equals the loaded PC.
- R9: `rd_err_i` on either read, or `fault_i` while running before `first_retire_i`, sets `fault_o` and clears `run_o`. `fault_o` stays set until reset. `fault_i` after the first retire has no effect.
- R10: a write with `sup_we_i` (select 0 = SR low 16 bits, 1 = VBR, 2 = memory enables) takes effect only after the first retire. Writes made earlier are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset request |
| halt_req_i | input | 1 | Debug halt request, sampled in the window |
| rd_req_o | output | 1 | Longword read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read completed, data valid |
| rd_err_i | input | 1 | Read ended with access/address error |
| rd_data_i | input | DW | Read data |
| fault_i | input | 1 | Access/address fault reported by the core |
| first_retire_i | input | 1 | First instruction has completed |
| sup_we_i | input | 1 | Supervisor register write strobe |
| sup_sel_i | input | 2 | Write target select |
| sup_wdata_i | input | DW | Write data |
| sr_o | output | 16 | Status register |
| vbr_o | output | DW | Vector base register |
| mem_en_o | output | N_MEM | Local-memory enables |
| sp_o | output | DW | Loaded stack pointer |
| pc_o | output | DW | Loaded program counter |
| run_o | output | 1 | Core released to execute |
| fetch_addr_o | output | AW | First fetch address |
| dbg_halt_o | output | 1 | Held by debug halt |
| fault_o | output | 1 | Fault-on-fault halt |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus:
- the supervisor registers keep their reset values until the core runs, and the fault flag stays set once raised;
- run, debug halt and fault never overlap, and no read is requested while halted or inside the window;
- only addresses 0 and 4 are ever read, an error always ends in the fault halt, and run rises only after the PC read is acknowledged.

The bench scenarios show what needs a stimulus history:
- the exact start cycle of the first read and the loaded SP/PC values;
- the resume after a held debug halt, and that a late halt request is ignored;
- that early writes and late faults are ignored;
- that reset drops the outputs at once, even mid-read.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT, ST_DHALT, ST_LDSP, ST_LDPC, ST_RUN, ST_ACTIVE, ST_FAULT
  } boot_st_e;

  typedef enum logic [1:0] {
    SEL_SR = 2'd0, SEL_VBR = 2'd1, SEL_MEM = 2'd2
  } sup_sel_e;

  // supervisor=1, trace=0, master=0, mask=7
  localparam logic [15:0] SR_RST = 16'h2700;
endpackage

// File: rtl/boot_seq_timer.sv
module boot_seq_timer #(
  parameter int DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_req_i,
  output logic done_o,
  output logic halt_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);
  localparam logic [CW-1:0] FULL = CW'(DLY);

  logic [CW-1:0] cnt_q;
  logic          halt_q;
  logic          open_w;

  assign open_w = (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (open_w) begin
      cnt_q <= cnt_q + CW'(1);
      if (halt_req_i) halt_q <= 1'b1;
    end
  end

  assign done_o = (cnt_q == LAST);
  assign halt_o = halt_q | halt_req_i;
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int              AW      = 32,
  parameter int              DW      = 32,
  parameter logic [AW-1:0]   SP_ADDR = '0,
  parameter logic [AW-1:0]   PC_ADDR = AW'(4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_done_i,
  input  logic          win_halt_i,
  input  logic          halt_req_i,
  input  logic          rd_ack_i,
  input  logic          rd_err_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          fault_i,
  input  logic          first_retire_i,
  output boot_st_e      state_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] pc_o
);
  boot_st_e st_q, st_d;
  logic [DW-1:0] sp_q, pc_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT:   if (win_done_i) st_d = win_halt_i ? ST_DHALT : ST_LDSP;
      ST_DHALT:  if (!halt_req_i) st_d = ST_LDSP;
      ST_LDSP:   if (rd_err_i) st_d = ST_FAULT;
                 else if (rd_ack_i) st_d = ST_LDPC;
      ST_LDPC:   if (rd_err_i) st_d = ST_FAULT;
                 else if (rd_ack_i) st_d = ST_RUN;
      ST_RUN:    if (fault_i) st_d = ST_FAULT;
                 else if (first_retire_i) st_d = ST_ACTIVE;
      ST_ACTIVE: st_d = ST_ACTIVE;
      ST_FAULT:  st_d = ST_FAULT;
      default:   st_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_WAIT;
      sp_q <= '0;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LDSP && rd_ack_i && !rd_err_i) sp_q <= rd_data_i;
      if (st_q == ST_LDPC && rd_ack_i && !rd_err_i) pc_q <= rd_data_i;
    end
  end

  assign state_o   = st_q;
  assign rd_req_o  = (st_q == ST_LDSP) || (st_q == ST_LDPC);
  assign rd_addr_o = (st_q == ST_LDPC) ? PC_ADDR : SP_ADDR;
  assign sp_o      = sp_q;
  assign pc_o      = pc_q;
endmodule

// File: rtl/boot_seq_regs.sv
module boot_seq_regs
  import boot_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int N_MEM = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [15:0]      sr_o,
  output logic [DW-1:0]    vbr_o,
  output logic [N_MEM-1:0] mem_en_o
);
  logic [15:0]   sr_q;
  logic [DW-1:0] vbr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= SR_RST;
      vbr_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_SR)  sr_q  <= wdata_i[15:0];
      if (sel_i == SEL_VBR) vbr_q <= wdata_i;
    end
  end

  // one enable flop per local memory, each invalidated by reset
  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else if (we_i && sel_i == SEL_MEM) en_q <= wdata_i[g];
    end
    assign mem_en_o[g] = en_q;
  end

  assign sr_o  = sr_q;
  assign vbr_o = vbr_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int DLY   = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int N_MEM = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_req_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_ack_i,
  input  logic             rd_err_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic             fault_i,
  input  logic             first_retire_i,
  input  logic             sup_we_i,
  input  logic [1:0]       sup_sel_i,
  input  logic [DW-1:0]    sup_wdata_i,
  output logic [15:0]      sr_o,
  output logic [DW-1:0]    vbr_o,
  output logic [N_MEM-1:0] mem_en_o,
  output logic [DW-1:0]    sp_o,
  output logic [DW-1:0]    pc_o,
  output logic             run_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             dbg_halt_o,
  output logic             fault_o
);
  boot_st_e state;
  logic     win_done, win_halt, wr_ok;

  boot_seq_timer #(.DLY(DLY)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_req_i (halt_req_i),
    .done_o     (win_done),
    .halt_o     (win_halt)
  );

  boot_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .win_done_i     (win_done),
    .win_halt_i     (win_halt),
    .halt_req_i     (halt_req_i),
    .rd_ack_i       (rd_ack_i),
    .rd_err_i       (rd_err_i),
    .rd_data_i      (rd_data_i),
    .fault_i        (fault_i),
    .first_retire_i (first_retire_i),
    .state_o        (state),
    .rd_req_o       (rd_req_o),
    .rd_addr_o      (rd_addr_o),
    .sp_o           (sp_o),
    .pc_o           (pc_o)
  );

  // supervisor writes only once the first instruction has retired
  assign wr_ok = sup_we_i && (state == ST_ACTIVE);

  boot_seq_regs #(.DW(DW), .N_MEM(N_MEM)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_ok),
    .sel_i    (sup_sel_i),
    .wdata_i  (sup_wdata_i),
    .sr_o     (sr_o),
    .vbr_o    (vbr_o),
    .mem_en_o (mem_en_o)
  );

  assign run_o        = (state == ST_RUN) || (state == ST_ACTIVE);
  assign dbg_halt_o   = (state == ST_DHALT);
  assign fault_o      = (state == ST_FAULT);
  assign fetch_addr_o = AW'(pc_o);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int DLY   = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int N_MEM = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_req_o,
  input logic [AW-1:0]    rd_addr_o,
  input logic             rd_ack_i,
  input logic             rd_err_i,
  input logic [15:0]      sr_o,
  input logic [DW-1:0]    vbr_o,
  input logic [N_MEM-1:0] mem_en_o,
  input logic             run_o,
  input logic             dbg_halt_o,
  input logic             fault_o
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (since_q != CW'(DLY)) since_q <= since_q + CW'(1);
  end

  a_r2_sr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> sr_o == 16'h2700);
  a_r3_vbr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> vbr_o == '0);
  a_r4_mem_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> mem_en_o == '0);
  a_r5_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> since_q == CW'(DLY));
  a_r6_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_halt_o |-> !rd_req_o && !run_o);
  a_r7_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o == AW'(0) || rd_addr_o == AW'(4)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !rd_err_i) |=> rd_req_o && $stable(rd_addr_o));
  a_r8_run_after_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(rd_req_o && rd_ack_i && rd_addr_o == AW'(4)));
  a_r9_err_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_err_i) |=> fault_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({run_o, dbg_halt_o, fault_o}));
endmodule

bind boot_seq boot_seq_chk #(.DLY(DLY), .AW(AW), .DW(DW), .N_MEM(N_MEM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_ack_i   (rd_ack_i),
  .rd_err_i   (rd_err_i),
  .sr_o       (sr_o),
  .vbr_o      (vbr_o),
  .mem_en_o   (mem_en_o),
  .run_o      (run_o),
  .dbg_halt_o (dbg_halt_o),
  .fault_o    (fault_o)
);

// File: tb/boot_seq_bench.sv
`timescale 1ns/1ps
module boot_seq_bench;
  localparam int DLY = 16, AW = 32, DW = 32, N_MEM = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req_i = 1'b0;
  logic rd_req_o, rd_ack_i = 1'b0, rd_err_i = 1'b0;
  logic [AW-1:0] rd_addr_o, fetch_addr_o;
  logic [DW-1:0] rd_data_i = '0, sup_wdata_i = '0, vbr_o, sp_o, pc_o;
  logic fault_i = 1'b0, first_retire_i = 1'b0, sup_we_i = 1'b0;
  logic [1:0] sup_sel_i = 2'd0;
  logic [15:0] sr_o;
  logic [N_MEM-1:0] mem_en_o;
  logic run_o, dbg_halt_o, fault_o;

  always #5 clk_i = ~clk_i;

  boot_seq #(.DLY(DLY), .AW(AW), .DW(DW), .N_MEM(N_MEM)) u_boot_seq (.*);

  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  logic [AW-1:0] err_addr = '1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: push the two expected boot reads
  task automatic expect_boot(input logic [DW-1:0] sp, input logic [DW-1:0] pc);
    q_addr.push_back('0);      q_data.push_back(sp);
    q_addr.push_back(AW'(4));  q_data.push_back(pc);
  endtask

  // monitor/responder: pops expected item per request and answers it
  always @(negedge clk_i) begin
    if (rd_ack_i || rd_err_i) begin
      rd_ack_i <= 1'b0; rd_err_i <= 1'b0;
    end else if (rd_req_o && rst_ni) begin
      if (q_addr.size() == 0) chk("R7 unexpected read", rd_addr_o, '1);
      else begin
        chk("R7 read address", rd_addr_o, q_addr.pop_front());
        rd_data_i <= q_data.pop_front();
      end
      if (rd_addr_o == err_addr) rd_err_i <= 1'b1;
      else rd_ack_i <= 1'b1;
    end
  end

  task automatic enter_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    q_addr.delete(); q_data.delete();
    err_addr = '1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic leave_reset();
    rst_ni = 1'b1;
  endtask

  task automatic wait_run(input string tag);
    for (int i = 0; i < 200; i++) begin
      if (run_o) break;
      @(negedge clk_i);
    end
    chk(tag, run_o, 1'b1);
  endtask

  task automatic wait_fault(input string tag);
    for (int i = 0; i < 200; i++) begin
      if (fault_o) break;
      @(negedge clk_i);
    end
    chk(tag, fault_o, 1'b1);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    sup_we_i = 1'b1; sup_sel_i = sel; sup_wdata_i = d;
    @(negedge clk_i);
    sup_we_i = 1'b0;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    // reset state
    repeat (3) @(negedge clk_i);
    chk("R2 sr in reset", sr_o, 16'h2700);
    chk("R3 vbr in reset", vbr_o, 0);
    chk("R4 mem in reset", mem_en_o, 0);
    chk("R1 no req in reset", {rd_req_o, run_o, dbg_halt_o, fault_o}, 0);

    // normal boot, exact window length
    expect_boot(32'h0000_8000, 32'h0000_0400);
    leave_reset();
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); n++;
      if (rd_req_o) break;
    end
    chk("R5 first read edge", n, DLY);
    wait_run("R8 run after boot");
    chk("R7 sp loaded", sp_o, 32'h0000_8000);
    chk("R7 pc loaded", pc_o, 32'h0000_0400);
    chk("R8 fetch addr", fetch_addr_o, 32'h0000_0400);
    chk("R7 both reads consumed", q_addr.size(), 0);
    chk("R2 sr before retire", sr_o, 16'h2700);
    wr(2'd1, 32'h1000_0000);
    chk("R10 early write ignored", vbr_o, 0);
    first_retire_i = 1'b1; @(negedge clk_i); first_retire_i = 1'b0;
    wr(2'd1, 32'h1000_0000);
    wr(2'd0, 32'h0000_0004);
    wr(2'd2, 32'h0000_000A);
    chk("R10 vbr written", vbr_o, 32'h1000_0000);
    chk("R10 sr written", sr_o, 16'h0004);
    chk("R10 mem written", mem_en_o, 4'hA);
    fault_i = 1'b1; @(negedge clk_i); fault_i = 1'b0;
    @(negedge clk_i);
    chk("R9 late fault ignored", {fault_o, run_o}, 2'b01);

    // reset mid-run restores everything
    @(negedge clk_i); #1 rst_ni = 1'b0; #1;
    chk("R1 run drops at once", run_o, 0);
    chk("R2 sr restored", sr_o, 16'h2700);
    chk("R3 vbr cleared", vbr_o, 0);
    chk("R4 mem invalidated", mem_en_o, 0);
    enter_reset();

    // debug halt held in window
    halt_req_i = 1'b1;
    expect_boot(32'h0000_2000, 32'h0000_0100);
    leave_reset();
    repeat (40) @(negedge clk_i);
    chk("R6 halted", {dbg_halt_o, rd_req_o, run_o}, 3'b100);
    halt_req_i = 1'b0;
    wait_run("R6 resume after halt");
    chk("R6 pc after halt", pc_o, 32'h0000_0100);

    // halt raised after window ignored
    enter_reset();
    expect_boot(32'h0000_3000, 32'h0000_0200);
    leave_reset();
    repeat (DLY) @(negedge clk_i);
    halt_req_i = 1'b1;
    wait_run("R6 late halt ignored");
    chk("R6 no dbg halt", dbg_halt_o, 0);
    halt_req_i = 1'b0;

    // reset during a read aborts it
    enter_reset();
    expect_boot(32'h1, 32'h2);
    leave_reset();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (rd_req_o) break;
    end
    #1 rst_ni = 1'b0; #1;
    chk("R1 read aborted", rd_req_o, 0);

    // error on SP read
    enter_reset();
    expect_boot(32'h1, 32'h2);
    err_addr = '0;
    leave_reset();
    wait_fault("R9 sp read error");
    repeat (30) @(negedge clk_i);
    chk("R9 fault sticky", {fault_o, run_o, rd_req_o}, 3'b100);

    // error on PC read
    enter_reset();
    expect_boot(32'h5, 32'h6);
    err_addr = AW'(4);
    leave_reset();
    wait_fault("R9 pc read error");
    chk("R9 no run", run_o, 0);

    // core fault before first retire
    enter_reset();
    expect_boot(32'h7, 32'h8);
    leave_reset();
    wait_run("R8 run before fault");
    fault_i = 1'b1; @(negedge clk_i); fault_i = 1'b0;
    chk("R9 early fault", {fault_o, run_o}, 2'b10);
    repeat (20) @(negedge clk_i);
    chk("R9 still faulted", fault_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule